// File: doc/BRIEF.md
# Link Receive Flit Integrity Filter

This block sits behind the receiver of a serial link between chips. Packets arrive as a stream of flits. Every flit is a codeword that protects its data word with a single-error-correct, double-error-detect code. The final flit of a packet carries a CRC-32 of the packet's payload words. The block repairs any flit with one flipped bit and flags any flit with two flipped bits. It computes the CRC over the repaired payload and compares it with the value in the tail. Errors of three or more bits can slip past the flit code, and the CRC catches them at the end of the packet.

Payload words are held in a packet-sized buffer until the tail arrives. The packet is then released whole or discarded whole. A discarded packet leaves no trace on the output, and nothing is requested from the sender. Released packets leave on a valid/ready stream with first-flit and last-flit markers. The tail flit is not forwarded. The output interface follows the usual valid/ready rules. While `out_valid` is high and `out_ready` is low, the offered flit and its markers stay unchanged. The input side stops accepting flits (`in_ready` low) while a committed packet drains. Three saturating event counters are driven on plain output pins.

Top module: `lnk_flit_filter`

## Requirements
- R1: Codeword layout. Bit k-1 holds Hamming position k for k = 1..DATA_W+6. Check bits sit at positions 1, 2, 4, 8, 16 and 32, and the data bits fill the remaining positions in ascending order. The top bit makes the overall parity of the codeword even. A flip of any single codeword bit, including a check bit or the parity bit, is repaired, and the original data is forwarded.
- R2: A flit with two flipped bits marks its packet uncorrectable, whether it is a payload flit or the tail. When the tail is accepted, the packet is discarded and `cnt_ecc_drop` advances by one.
- R3: The CRC uses the reflected 802.3 polynomial 0xEDB88320 with initial value 0xFFFFFFFF and a final inversion. It runs over the corrected payload words in arrival order, each word LSB first. If the tail's low 32 data bits differ from the CRC and R2 did not apply, the packet is discarded and `cnt_crc_drop` advances by one.
- R4: A discarded packet produces no output flit, and the packets that follow it are forwarded normally.
- R5: A clean packet with 1 to MAX_FLITS payload flits is forwarded in order. `out_sop` is set on its first flit and `out_eop` on its last, and the tail flit is not forwarded.
- R6: `in_ready` is low from the acceptance of a committing tail until the handshake of the last output flit. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values.
- R7: `cnt_corrected` advances by one for every accepted flit that had a single-bit repair, whatever happens to its packet.
- R8: Each counter stops at 2^CNT_W-1.
- R9: A packet with more than MAX_FLITS payload flits and no double-bit flit is discarded. It produces no output and changes no drop counter.
- R10: During reset, `out_valid` is low, `in_ready` is high and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input flit offered |
| in_ready | output | 1 | Block accepts the offered flit |
| in_cw | input | DATA_W+7 | Protected flit codeword |
| in_last | input | 1 | Flit is the CRC tail of its packet |
| out_valid | output | 1 | Output flit offered |
| out_ready | input | 1 | Downstream accepts the output flit |
| out_data | output | DATA_W | Corrected payload word |
| out_sop | output | 1 | First flit of a packet |
| out_eop | output | 1 | Last flit of a packet |
| cnt_corrected | output | CNT_W | Flits repaired by the flit code |
| cnt_ecc_drop | output | CNT_W | Packets discarded for a double-bit flit |
| cnt_crc_drop | output | CNT_W | Packets discarded for a CRC mismatch |

## Verification
Directed packets flip each of the 39 codeword bits once. This separates a correct syndrome-to-position map from one that mislocates check or parity bits. Packets that carry two flips, one in the payload and one in the tail, are paired with packets whose tail CRC is wrong but whose flits are all clean, which keeps the two drop counters apart. Lengths of exactly MAX_FLITS and MAX_FLITS+1 probe the buffer limit. Random packets with mixed error kinds, random gaps and random downstream stalls then test ordering, marker placement and holding under back-pressure. A long run of bad-CRC packets drives the counters into saturation.

// File: rtl/lf_pkg.sv
package lf_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic {ST_RECV, ST_DRAIN} lf_state_e;

  // number of Hamming check bits for a data width
  function automatic int par_bits(int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // full codeword width: data, check bits, overall parity
  function automatic int cw_width(int dw);
    return dw + par_bits(dw) + 1;
  endfunction

  // 1-based Hamming position of data bit idx (skips powers of two)
  function automatic int data_pos(int idx);
    int p;
    int k;
    p = 0;
    k = -1;
    while (k < idx) begin
      p++;
      if ((p & (p - 1)) != 0) k++;
    end
    return p;
  endfunction

endpackage

// File: rtl/lf_secded_dec.sv
module lf_secded_dec #(
  parameter int DATA_W = 32
) (
  input  logic [lf_pkg::cw_width(DATA_W)-1:0] cw_i,
  output logic [DATA_W-1:0]                   data_o,
  output logic                                single_o,
  output logic                                double_o
);
  localparam int R  = lf_pkg::par_bits(DATA_W);
  localparam int HW = DATA_W + R;

  logic [R-1:0]  syn;
  logic          par;
  logic [HW-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int i = 0; i < HW; i++) begin
      if (cw_i[i]) syn = syn ^ R'(i + 1);
    end
    par      = ^cw_i;
    fixed    = cw_i[HW-1:0];
    single_o = 1'b0;
    double_o = 1'b0;
    if (par) begin
      // odd weight: one flip, in a Hamming bit or in the parity bit
      if (syn == '0) begin
        single_o = 1'b1;
      end else if (int'(syn) <= HW) begin
        single_o = 1'b1;
        for (int i = 0; i < HW; i++) begin
          if (int'(syn) == i + 1) fixed[i] = ~fixed[i];
        end
      end else begin
        double_o = 1'b1;
      end
    end else if (syn != '0) begin
      double_o = 1'b1;
    end
  end

  for (genvar d = 0; d < DATA_W; d++) begin : g_extract
    localparam int POS = lf_pkg::data_pos(d);
    assign data_o[d] = fixed[POS-1];
  end

endmodule

// File: rtl/lf_crc32.sv
module lf_crc32 #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [31:0]       crc_o
);
  logic [31:0] c_q;
  logic [31:0] c_n;

  always_comb begin
    c_n = c_q;
    for (int i = 0; i < DATA_W; i++) begin
      if (c_n[0] ^ din[i]) c_n = (c_n >> 1) ^ lf_pkg::CRC_POLY;
      else                 c_n = c_n >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   c_q <= '1;
    else if (clr) c_q <= '1;
    else if (en)  c_q <= c_n;
  end

  assign crc_o = ~c_q;

endmodule

// File: rtl/lf_pkt_store.sv
module lf_pkt_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lf_sat_ctr.sv
module lf_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
  end

  // R8: once full the counter stays full
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |=> (cnt == '1));

  // R7: a counted event below the limit moves the count by exactly one
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/lnk_flit_filter.sv
module lnk_flit_filter #(
  parameter int DATA_W    = 32,
  parameter int MAX_FLITS = 16,
  parameter int CNT_W     = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [lf_pkg::cw_width(DATA_W)-1:0] in_cw,
  input  logic                                in_last,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [DATA_W-1:0]                   out_data,
  output logic                                out_sop,
  output logic                                out_eop,
  output logic [CNT_W-1:0]                    cnt_corrected,
  output logic [CNT_W-1:0]                    cnt_ecc_drop,
  output logic [CNT_W-1:0]                    cnt_crc_drop
);
  localparam int AW  = $clog2(MAX_FLITS);
  localparam int LW  = $clog2(MAX_FLITS + 1);
  localparam int NCT = 3;

  lf_pkg::lf_state_e st_q;

  logic [DATA_W-1:0] dec_data;
  logic              dec_single;
  logic              dec_double;
  logic [31:0]       crc_val;

  logic [LW-1:0] wcnt_q;
  logic [LW-1:0] len_q;
  logic [AW-1:0] rptr_q;
  logic          ecc_bad_q;
  logic          ovf_q;

  logic acc, acc_body, acc_tail;
  logic full, ecc_fail, crc_ok, commit;
  logic rd_hs, rd_last;
  logic [NCT-1:0]   inc_vec;
  logic [CNT_W-1:0] cnt_arr [NCT];

  lf_secded_dec #(.DATA_W(DATA_W)) u_dec (
    .cw_i     (in_cw),
    .data_o   (dec_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  assign in_ready = (st_q == lf_pkg::ST_RECV);
  assign acc      = in_valid && in_ready;
  assign acc_body = acc && !in_last;
  assign acc_tail = acc && in_last;
  assign full     = (wcnt_q == LW'(MAX_FLITS));

  lf_crc32 #(.DATA_W(DATA_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_tail),
    .en    (acc_body),
    .din   (dec_data),
    .crc_o (crc_val)
  );

  lf_pkt_store #(.DATA_W(DATA_W), .DEPTH(MAX_FLITS)) u_store (
    .clk   (clk),
    .we    (acc_body && !full),
    .waddr (wcnt_q[AW-1:0]),
    .wdata (dec_data),
    .raddr (rptr_q),
    .rdata (out_data)
  );

  assign ecc_fail = ecc_bad_q || dec_double;
  assign crc_ok   = (crc_val == dec_data[31:0]);
  assign commit   = acc_tail && !ecc_fail && !ovf_q && crc_ok && (wcnt_q != '0);

  assign out_valid = (st_q == lf_pkg::ST_DRAIN);
  assign out_sop   = out_valid && (rptr_q == '0);
  assign rd_last   = ((LW'(rptr_q) + LW'(1)) == len_q);
  assign out_eop   = out_valid && rd_last;
  assign rd_hs     = out_valid && out_ready;

  // receive bookkeeping for the packet being gathered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q    <= '0;
      ecc_bad_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (acc_tail) begin
      wcnt_q    <= '0;
      ecc_bad_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (acc_body) begin
      if (dec_double) ecc_bad_q <= 1'b1;
      if (full) ovf_q  <= 1'b1;
      else      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  // commit / drain sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= lf_pkg::ST_RECV;
      len_q  <= '0;
      rptr_q <= '0;
    end else begin
      case (st_q)
        lf_pkg::ST_RECV: begin
          if (commit) begin
            st_q   <= lf_pkg::ST_DRAIN;
            len_q  <= wcnt_q;
            rptr_q <= '0;
          end
        end
        default: begin
          if (rd_hs) begin
            if (rd_last) st_q   <= lf_pkg::ST_RECV;
            else         rptr_q <= rptr_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign inc_vec[0] = acc && dec_single;
  assign inc_vec[1] = acc_tail && ecc_fail;
  assign inc_vec[2] = acc_tail && !ecc_fail && !ovf_q && !crc_ok;

  for (genvar g = 0; g < NCT; g++) begin : g_cnt
    lf_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_vec[g]),
      .cnt   (cnt_arr[g])
    );
  end

  assign cnt_corrected = cnt_arr[0];
  assign cnt_ecc_drop  = cnt_arr[1];
  assign cnt_crc_drop  = cnt_arr[2];

  // R6: a stalled output flit is held
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  // R5: every burst of output flits opens with a start marker
  p_sop_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sop);

  // R5/R6: the end marker's handshake returns the block to receiving
  p_eop_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> (!out_valid && in_ready));

  // R4: a tail closing an uncorrectable packet starts no output
  p_drop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && (dec_double || ecc_bad_q)) |=> !out_valid);

endmodule

// File: tb/lnk_flit_filter_bench.sv
module lnk_flit_filter_bench;
  localparam int DW   = 32;
  localparam int MAXF = 16;
  localparam int CW   = 39;
  localparam int CNTW = 8;
  localparam int CMAX = (1 << CNTW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_last;
  logic [CW-1:0] in_cw;
  logic out_valid, out_ready, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic [CNTW-1:0] cnt_corrected, cnt_ecc_drop, cnt_crc_drop;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  lnk_flit_filter #(.DATA_W(DW), .MAX_FLITS(MAXF), .CNT_W(CNTW)) u_lnk_flit_filter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_cw(in_cw), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .cnt_corrected(cnt_corrected), .cnt_ecc_drop(cnt_ecc_drop), .cnt_crc_drop(cnt_crc_drop)
  );

  int total = 0;
  int bad   = 0;
  int m_corr = 0, m_ecc = 0, m_crc = 0;
  bit rnd_rdy = 0, rnd_gap = 0;
  logic [31:0] pay [MAXF+4];
  int          ferr [MAXF+5];
  logic [33:0] expq [$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic logic [CW-1:0] enc(logic [31:0] d);
    logic [CW-1:0] c;
    int k;
    bit p;
    c = '0;
    k = 0;
    for (int q = 1; q <= 38; q++) begin
      if ((q & (q - 1)) != 0) begin c[q-1] = d[k]; k++; end
    end
    for (int j = 0; j < 6; j++) begin
      p = 0;
      for (int q = 1; q <= 38; q++) if (((q >> j) & 1) != 0) p ^= c[q-1];
      c[(1 << j) - 1] = p;
    end
    c[38] = ^c[37:0];
    return c;
  endfunction

  function automatic logic [31:0] crc_ref(int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < 32; b++) begin
        if (c[0] ^ pay[w][b]) c = (c >> 1) ^ 32'hEDB88320;
        else                  c = c >> 1;
      end
    return ~c;
  endfunction

  task automatic fill(int len);
    for (int i = 0; i < len; i++) pay[i] = $urandom;
    for (int i = 0; i <= len; i++) ferr[i] = 0;
  endtask

  task automatic send_pkt(int len, bit crc_bad);
    logic [31:0] tail, d;
    logic [CW-1:0] cw;
    bit dbl;
    int b1, b2;
    tail = crc_ref(len) ^ (crc_bad ? 32'h0000_0100 : 32'h0);
    dbl = 0;
    for (int i = 0; i <= len; i++) begin
      if (ferr[i] == 2) dbl = 1;
      if (ferr[i] == 1 || ferr[i] >= 10) m_corr++;
    end
    if (dbl) m_ecc++;
    else if (len > MAXF) begin end
    else if (crc_bad) m_crc++;
    else
      for (int i = 0; i < len; i++)
        expq.push_back({i == 0, i == len - 1, pay[i]});
    for (int i = 0; i <= len; i++) begin
      d  = (i < len) ? pay[i] : tail;
      cw = enc(d);
      if (ferr[i] == 1) begin b1 = $urandom % CW; cw[b1] = ~cw[b1]; end
      if (ferr[i] == 2) begin
        b1 = $urandom % CW;
        b2 = (b1 + 1 + ($urandom % (CW - 1))) % CW;
        cw[b1] = ~cw[b1];
        cw[b2] = ~cw[b2];
      end
      if (ferr[i] >= 10) cw[ferr[i]-10] = ~cw[ferr[i]-10];
      @(negedge clk);
      if (rnd_gap && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_cw    = cw;
      in_last  = (i == len);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    while (expq.size() != 0 || out_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_counters(string tag);
    chk({"R7 corrected ", tag}, 64'(cnt_corrected), 64'(sat(m_corr)));
    chk({"R2 ecc drops ", tag}, 64'(cnt_ecc_drop),  64'(sat(m_ecc)));
    chk({"R3 crc drops ", tag}, 64'(cnt_crc_drop),  64'(sat(m_crc)));
  endtask

  // output monitor: drives out_ready, compares every accepted flit
  initial begin : monitor
    logic [33:0] prev_word;
    logic [33:0] e;
    bit prev_stall;
    prev_stall = 0;
    prev_word  = '0;
    out_ready  = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (rst_n && out_valid) begin
        chk("R6 in_ready low while draining", 64'(in_ready), 64'd0);
        if (prev_stall) chk("R6 flit held under stall", 64'({out_sop, out_eop, out_data}), 64'(prev_word));
        if (out_ready) begin
          if (expq.size() == 0) begin
            total++; bad++;
            $display("FAIL R4 unexpected flit act=%0h exp=none", {out_sop, out_eop, out_data});
          end else begin
            e = expq.pop_front();
            chk("R5 forwarded flit", 64'({out_sop, out_eop, out_data}), 64'(e));
          end
        end
        prev_stall = !out_ready;
        prev_word  = {out_sop, out_eop, out_data};
      end else begin
        if (prev_stall) chk("R6 valid held under stall", 64'(out_valid), 64'd1);
        prev_stall = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int len;
    int r;
    bit cb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_cw = '0;
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R10 in_ready in reset",  64'(in_ready),  64'd1);
    chk_counters("R10 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R5: single flit clean packet
    fill(1); send_pkt(1, 0); settle();
    chk_counters("after clean");

    // R1: one flip in each of the 39 codeword positions
    fill(13); for (int i = 0; i <= 13; i++) ferr[i] = 10 + i;      send_pkt(13, 0);
    fill(13); for (int i = 0; i <= 13; i++) ferr[i] = 10 + 14 + i; send_pkt(13, 0);
    fill(10); for (int i = 0; i <= 10; i++) ferr[i] = 10 + 28 + i; send_pkt(10, 0);
    settle();
    chk_counters("R1 sweep");

    // R2: double flip in payload, then in tail; R4: clean packet after
    fill(5); ferr[2] = 2; send_pkt(5, 0);
    fill(4); ferr[4] = 2; send_pkt(4, 0);
    fill(3); send_pkt(3, 0);
    settle();
    chk_counters("R2 double");

    // R3: wrong CRC with clean flits; R4: follow-up packet intact
    fill(6); send_pkt(6, 1);
    fill(2); send_pkt(2, 0);
    settle();
    chk_counters("R3 crc");

    // R9: exact limit passes, one over is discarded silently
    fill(MAXF); send_pkt(MAXF, 0);
    fill(MAXF + 1); send_pkt(MAXF + 1, 0);
    fill(MAXF + 3); send_pkt(MAXF + 3, 1);
    fill(1); send_pkt(1, 0);
    settle();
    chk_counters("R9 length");

    // random mix with stalls and gaps
    rnd_rdy = 1; rnd_gap = 1;
    for (int p = 0; p < 200; p++) begin
      len = 1 + ($urandom % MAXF);
      if ($urandom % 20 == 0) len = MAXF + 1 + ($urandom % 3);
      fill(len);
      for (int i = 0; i <= len; i++) begin
        r = $urandom % 100;
        if (r < 15)      ferr[i] = 1;
        else if (r < 18) ferr[i] = 2;
      end
      cb = ($urandom % 12 == 0);
      send_pkt(len, cb);
    end
    settle();
    chk_counters("random");

    // R8: push counters to their ceiling
    rnd_rdy = 0; rnd_gap = 0;
    for (int p = 0; p < 270; p++) begin
      fill(1); ferr[0] = 1; send_pkt(1, 1);
    end
    for (int p = 0; p < 260; p++) begin
      fill(1); ferr[1] = 2; send_pkt(1, 0);
    end
    settle();
    chk("R8 crc counter saturated", 64'(cnt_crc_drop),  64'(CMAX));
    chk("R8 ecc counter saturated", 64'(cnt_ecc_drop),  64'(CMAX));
    chk("R8 corrected saturated",   64'(cnt_corrected), 64'(CMAX));
    fill(2); send_pkt(2, 0); settle();
    chk_counters("R8 after saturation");
    chk("R4 queue drained", 64'(expq.size()), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule